// File: doc/BRIEF.md
# Two-Wire Register Access Master

This block is the master side of a two-wire serial management link used to read and write 16-bit registers, at 16-bit addresses, in one attached slave device. A host issues a one-cycle request carrying a read/write flag, an address and write data. The block then runs the whole exchange on the serial clock line and the bidirectional data line. When the lines are released it returns the read data, an error flag and a one-cycle completion pulse.

A transfer runs in a fixed order. First comes a lead-in clock pulse and a start condition. Then the master sends an 8-bit control header, the address bytes, and either the write-data bytes or the read-data bytes. A stop condition with trailing clock pulses ends it. Each byte the master sends is followed by a slave acknowledge slot, and a slot that is not acknowledged is read again a bounded number of times. The data line is split into output-value, output-enable and input signals, so the pad, or a bench model of the slave, can share the wire. Each clock level lasts a parameterised number of system clocks.

Top module: `smi_master`

## Requirements
- R1: After reset, and whenever no transfer is running, both line enables are 0 (lines released), `busy` is 0 and `rsp_done` is 0.
- R2: A request is taken only while `busy` is 0. A request raised while a transfer runs has no effect: that transfer keeps its address and no second transfer follows.
- R3: On acceptance the master drives the clock low and the data line high. It gives one full clock pulse, then a start condition: clock high, data falls while the clock stays high, clock low, data high. Exactly two clock rising edges come before the data falls.
- R4: The first eight bits after the start are 1,0,1,1,1,0,0 and then the R/W bit (1 = read, 0 = write), sent MSB first. Each bit is set while the clock is low and is valid during the following high level.
- R5: The address follows the header's acknowledge slot: bits 7:0, an acknowledge slot, bits 15:8, an acknowledge slot, each byte MSB first.
- R6: On a write, data bits 7:0, an acknowledge slot, data bits 15:8 and an acknowledge slot follow the address.
- R7: On a read, the master releases the data line and samples it during each high clock level. It receives data bits 7:0, then bits 15:8, each MSB first, and returns them on `rsp_rdata`.
- R8: On a read, the master drives a 0 in the bit slot after the low data byte and a 1 in the bit slot after the high data byte.
- R9: In an acknowledge slot the master releases the line and reads one bit, where 0 means acknowledged. A 1 is read again, up to `ACK_TRIES` reads in total. An acknowledge within that limit leaves `rsp_err` at 0.
- R10: When all `ACK_TRIES` reads of a slot return 1, `rsp_err` becomes 1. The transfer still runs through every remaining slot, the stop and the release.
- R11: The stop raises data while the clock is high, after data was low under a high clock. Exactly two further clock rising edges follow, then both lines are released.
- R12: Once the clock line changes level, it holds that level for at least `HALF_CYC` system clocks.
- R13: `rsp_done` is high for exactly one cycle per transfer, in the cycle the lines are released. `rsp_rdata` and `rsp_err` then hold until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, one cycle |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_addr | input | 16 | Register address |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Data returned by a read |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | An acknowledge slot ran out of reads |
| busy | output | 1 | Transfer in progress |
| sck_o | output | 1 | Clock line value |
| sck_oe | output | 1 | Clock line drive enable |
| sda_o | output | 1 | Data line value when driven |
| sda_oe | output | 1 | Data line drive enable |
| sda_i | input | 1 | Data line as seen on the wire |

## Verification
The bench builds the block with `HALF_CYC` = 2 and `ACK_TRIES` = 3. The short half-period keeps a full transfer to a few hundred cycles, so the vector table covers reads and writes with extreme address and data patterns. A limit of three reads lets the slave model both refuse a slot fewer times than the limit and refuse it until the limit runs out, in header, address, data and final slots. A half-period above one also makes the minimum level-hold check meaningful.

// File: rtl/smi_master.sv
module smi_master #(
  parameter int HALF_CYC  = 4,
  parameter int ACK_TRIES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        req_rd,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_wdata,
  output logic [15:0] rsp_rdata,
  output logic        rsp_done,
  output logic        rsp_err,
  output logic        busy,
  output logic        sck_o,
  output logic        sck_oe,
  output logic        sda_o,
  output logic        sda_oe,
  input  logic        sda_i
);

  localparam int CW = (HALF_CYC  > 1) ? $clog2(HALF_CYC)  : 1;
  localparam int TW = (ACK_TRIES > 1) ? $clog2(ACK_TRIES) : 1;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_START, S_TX, S_RX, S_ACK, S_STOP} st_t;

  st_t         st, nst;
  logic [2:0]  ph;
  logic [3:0]  k, kn, nb, nbits;
  logic [7:0]  sh, nbyte;
  logic [CW-1:0] dcnt;
  logic [TW-1:0] tries;
  logic        rd;
  logic [15:0] addr, wdat;
  logic        tick, last, adv;

  assign busy = (st != S_IDLE);
  assign tick = busy && (dcnt == '0);
  assign adv  = tick && last;

  always_comb begin
    kn    = k + 4'd1;
    nst   = S_STOP;
    nbyte = '0;
    nbits = 4'd8;
    case (kn)
      4'd0: begin nst = S_TX; nbyte = {7'b1011100, rd}; end
      4'd1, 4'd3, 4'd5: nst = S_ACK;
      4'd2: begin nst = S_TX; nbyte = addr[7:0]; end
      4'd4: begin nst = S_TX; nbyte = addr[15:8]; end
      4'd6: begin nst = rd ? S_RX : S_TX; nbyte = wdat[7:0]; end
      4'd8: begin nst = rd ? S_RX : S_TX; nbyte = wdat[15:8]; end
      4'd7, 4'd9: begin
        nst   = rd ? S_TX : S_ACK;
        nbyte = {kn == 4'd9, 7'b0};
        nbits = 4'd1;
      end
      default: nst = S_STOP;
    endcase
  end

  always_comb begin
    case (st)
      S_START:    last = (ph == 3'd3);
      S_TX, S_RX: last = (ph == 3'd2) && (nb == 4'd1);
      S_ACK:      last = (ph == 3'd2) && (!sda_i || tries == TW'(ACK_TRIES - 1));
      default:    last = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; k <= '0; nb <= '0; sh <= '0; dcnt <= '0; tries <= '0;
      rd <= 1'b0; addr <= '0; wdat <= '0;
      rsp_rdata <= '0; rsp_done <= 1'b0; rsp_err <= 1'b0;
      sck_o <= 1'b0; sck_oe <= 1'b0; sda_o <= 1'b1; sda_oe <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      if (st == S_IDLE) begin
        if (req) begin
          st <= S_PRE; ph <= 3'd1; k <= 4'hF; tries <= '0;
          dcnt <= CW'(HALF_CYC - 1);
          rd <= req_rd; addr <= req_addr; wdat <= req_wdata;
          rsp_err <= 1'b0;
          sck_o <= 1'b0; sck_oe <= 1'b1; sda_o <= 1'b1; sda_oe <= 1'b1;
        end
      end else if (!tick) begin
        dcnt <= dcnt - CW'(1);
      end else begin
        dcnt <= CW'(HALF_CYC - 1);
        ph   <= ph + 3'd1;
        case (st)
          S_PRE: begin
            sck_o <= (ph == 3'd1);
            if (ph == 3'd2) begin st <= S_START; ph <= '0; end
          end
          S_START: begin
            case (ph)
              3'd0:    sck_o <= 1'b1;
              3'd1:    sda_o <= 1'b0;
              3'd2:    sck_o <= 1'b0;
              default: sda_o <= 1'b1;
            endcase
          end
          S_TX: begin
            case (ph)
              3'd0: begin sda_oe <= 1'b1; sda_o <= sh[7]; end
              3'd1: sck_o <= 1'b1;
              default: begin
                sck_o <= 1'b0; sh <= {sh[6:0], 1'b0}; nb <= nb - 4'd1; ph <= '0;
              end
            endcase
          end
          S_RX: begin
            case (ph)
              3'd0: sda_oe <= 1'b0;
              3'd1: sck_o <= 1'b1;
              default: begin
                sck_o <= 1'b0; nb <= nb - 4'd1; ph <= '0;
                if (k == 4'd6) rsp_rdata[7:0]  <= {rsp_rdata[6:0],  sda_i};
                else           rsp_rdata[15:8] <= {rsp_rdata[14:8], sda_i};
              end
            endcase
          end
          S_ACK: begin
            case (ph)
              3'd0: sda_oe <= 1'b0;
              3'd1: sck_o <= 1'b1;
              default: begin
                sck_o <= 1'b0;
                if (!sda_i) tries <= '0;
                else if (tries == TW'(ACK_TRIES - 1)) begin rsp_err <= 1'b1; tries <= '0; end
                else begin tries <= tries + TW'(1); ph <= '0; end
              end
            endcase
          end
          S_STOP: begin
            case (ph)
              3'd0: begin sda_oe <= 1'b1; sda_o <= 1'b0; sck_o <= 1'b1; end
              3'd1: sda_o <= 1'b1;
              3'd2, 3'd4: sck_o <= 1'b0;
              3'd3, 3'd5: sck_o <= 1'b1;
              default: begin
                sck_oe <= 1'b0; sda_oe <= 1'b0; sck_o <= 1'b0; sda_o <= 1'b1;
                rsp_done <= 1'b1; st <= S_IDLE; ph <= '0;
              end
            endcase
          end
          default: st <= S_IDLE;
        endcase
        if (adv) begin
          st <= nst; sh <= nbyte; nb <= nbits; k <= kn; ph <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/smi_master_chk.sv
module smi_master_chk #(
  parameter int HALF_CYC = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic [15:0] rsp_rdata,
  input logic        rsp_done,
  input logic        rsp_err,
  input logic        busy,
  input logic        sck_o,
  input logic        sck_oe,
  input logic        sda_o,
  input logic        sda_oe
);

  logic        prev_sck;
  logic [15:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_sck <= 1'b0;
      run      <= 16'hFFFF;
    end else begin
      prev_sck <= sck_o;
      run      <= (sck_o != prev_sck) ? 16'd1 : ((run == 16'hFFFF) ? run : run + 16'd1);
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sck_oe && !sda_oe)); // R1

  AST_START_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req)); // R2

  AST_LEAD_IN_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (sck_oe && sda_oe && !sck_o && sda_o)); // R3

  AST_SCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_o != prev_sck) |-> (run >= 16'(HALF_CYC))); // R12

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R13

  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (!busy && !sck_oe && !sda_oe)); // R13

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req) |=> ($stable(rsp_rdata) && $stable(rsp_err))); // R13

endmodule

bind smi_master smi_master_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
  .rsp_err(rsp_err), .busy(busy), .sck_o(sck_o), .sck_oe(sck_oe), .sda_o(sda_o), .sda_oe(sda_oe)
);

// File: tb/tb_smi_master.sv
`timescale 1ns/1ps
module tb_smi_master;
  localparam int HALF  = 2;
  localparam int TRIES = 3;
  localparam int NV    = 7;

  // {rd, addr, data, nak_slot, nak_count}
  localparam logic [44:0] VEC [0:NV-1] = '{
    {1'b0, 16'h1234, 16'hABCD, 8'd0,  4'd0},
    {1'b1, 16'h00FF, 16'h5AA5, 8'd0,  4'd0},
    {1'b0, 16'hFF00, 16'h0001, 8'd17, 4'd2},
    {1'b1, 16'h8001, 16'hFFFF, 8'd8,  4'd3},
    {1'b0, 16'hA5C3, 16'h8000, 8'd44, 4'd5},
    {1'b1, 16'h0000, 16'h0000, 8'd26, 4'd1},
    {1'b0, 16'hFFFF, 16'hFFFF, 8'd35, 4'd3}
  };

  logic clk = 0, rst_n = 0, req = 0, req_rd = 0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [15:0] rsp_rdata;
  logic rsp_done, rsp_err, busy, sck_o, sck_oe, sda_o, sda_oe;
  logic sda_line, slv_val;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  assign sda_line = sda_oe ? sda_o : slv_val;

  smi_master #(.HALF_CYC(HALF), .ACK_TRIES(TRIES)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_rd(req_rd), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .busy(busy), .sck_o(sck_o), .sck_oe(sck_oe), .sda_o(sda_o), .sda_oe(sda_oe), .sda_i(sda_line)
  );

  // slave model
  logic act = 0, skip = 0, psck = 0, psda = 1;
  logic [63:0] cap = '0;
  logic [15:0] rdv = '0;
  int pos = 0, nak_slot = 0, nak_left = 0, tries_seen = 0;
  int idle_rises = 0, pre_rises = 0, starts = 0, stops = 0, dones = 0, run = 1000, tim_bad = 0;

  function automatic logic is_ack(int p);
    return (p == 8) || (p == 17) || (p == 26) || (!cap[7] && (p == 35 || p == 44));
  endfunction

  function automatic logic [7:0] getb(int p);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[7-i] = cap[p+i];
    return b;
  endfunction

  always_comb begin
    slv_val = 1'b1;
    if (act) begin
      if (is_ack(pos)) slv_val = (pos == nak_slot && nak_left > 0);
      else if (cap[7] && pos >= 27 && pos <= 34) slv_val = rdv[7-(pos-27)];
      else if (cap[7] && pos >= 36 && pos <= 43) slv_val = rdv[15-(pos-36)];
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_done) dones++;
      if (sck_o != psck) begin
        if (run < HALF) tim_bad++;
        run = 1;
      end else if (run < 1000) run++;
      if (!psck && sck_o && sck_oe) begin
        if (act) cap[pos] = sda_line;
        else idle_rises++;
      end
      if (psck && sck_o && psda && !sda_line && sck_oe && sda_oe && !act) begin
        act = 1; skip = 1; pos = 0; tries_seen = 0; starts++; pre_rises = idle_rises;
      end else if (act && psck && sck_o && !psda && sda_line) begin
        act = 0; stops++;
      end else if (act && psck && !sck_o) begin
        if (skip) skip = 0;
        else if (is_ack(pos)) begin
          logic naked;
          naked = (pos == nak_slot && nak_left > 0);
          if (naked) nak_left--;
          tries_seen++;
          if (naked && tries_seen < TRIES) ;
          else begin pos++; tries_seen = 0; end
        end else pos++;
      end
    end
    psck = sck_o;
    psda = sda_line;
  end

  task automatic check(string tag, logic [31:0] act_v, logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  task automatic run_txn(logic rd, logic [15:0] a, logic [15:0] d, int slot, int nn, bit poke);
    int w;
    nak_slot = slot; nak_left = nn; rdv = d; cap = '0;
    idle_rises = 0; pre_rises = 0; starts = 0; stops = 0; dones = 0; tim_bad = 0;
    @(negedge clk); req = 1; req_rd = rd; req_addr = a; req_wdata = d;
    @(negedge clk); req = 0;
    if (poke) begin
      repeat (30) @(negedge clk);
      req = 1; req_rd = ~rd; req_addr = ~a; req_wdata = ~d;
      @(negedge clk); req = 0;
    end
    w = 0;
    while (dones == 0 && w < 5000) begin @(negedge clk); w++; end
    repeat (40) @(negedge clk);
    check("R4 header", getb(0), {7'b1011100, rd});
    check("R5 addr low", getb(9), a[7:0]);
    check("R5 addr high", getb(18), a[15:8]);
    if (!rd) begin
      check("R6 data low", getb(27), d[7:0]);
      check("R6 data high", getb(36), d[15:8]);
    end else begin
      check("R7 read data", rsp_rdata, d);
      check("R8 ack after low", cap[35], 0);
      check("R8 final bit", cap[44], 1);
    end
    if (nn >= TRIES) check("R10 error set", rsp_err, 1);
    else             check("R9 no error", rsp_err, 0);
    check("R3 lead-in rises", pre_rises, 2);
    check("R3 one start", starts, poke ? 1 : 1);
    check("R11 stop seen", stops, 1);
    check("R11 trailing rises", idle_rises - pre_rises, 2);
    check("R11 released", {sck_oe, sda_oe, busy}, 0);
    check("R13 done count", dones, 1);
    check("R12 level hold", tim_bad, 0);
    if (poke) check("R2 single transfer", {starts, dones}, {32'd1, 32'd1});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset lines", {sck_oe, sda_oe, busy, rsp_done}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check("R1 idle after reset", {sck_oe, sda_oe, busy, rsp_done}, 0);
    for (int i = 0; i < NV; i++)
      run_txn(VEC[i][44], VEC[i][43:28], VEC[i][27:12], int'(VEC[i][11:4]), int'(VEC[i][3:0]), 0);
    // R2: request during busy is ignored
    run_txn(1'b0, 16'h3C5A, 16'h0F0F, 0, 0, 1);
    // R13: results hold while idle
    run_txn(1'b1, 16'h4242, 16'hC001, 8, 2, 0);
    repeat (100) @(negedge clk);
    check("R13 rdata held", rsp_rdata, 16'hC001);
    check("R13 err held", rsp_err, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule